// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, one frame at a time, whether a frame arriving at a receive port is kept or dropped. The decision depends only on the destination address. The address arrives one bit per cycle in wire order, and the block compares it with a programmed station address while it streams in. Once the last address bit has arrived, the block gives its verdict.

Four match modes set the policy:
- The receiver is switched off.
- Every frame is taken.
- Only frames for this station or for the all-ones broadcast address are taken.
- As above, and group addresses are also taken when a 64-entry hash table allows them.

For group addresses, the hash table is indexed by a 6-bit value that comes from the frame-check CRC over the destination address. A separate CRC engine supplies that index.

A frame-start strobe opens each evaluation. The surrounding receive logic reads the verdict and keeps or discards the frame payload to match. The station address is written through a simple write strobe. Writes that arrive while a frame is being evaluated are ignored, so the comparison always uses one stable address.

Top module: `rx_addr_filter`

## Requirements
- R1: With match mode 2'b00 (receiver off), every verdict is discard (`accept` = 0).
- R2: With match mode 2'b01 (promiscuous), every verdict is accept, whatever the destination.
- R3: With match mode 2'b10, a frame is accepted only when its 48-bit destination equals the station address or is all ones (broadcast). Other unicast and group frames are discarded.
- R4: With match mode 2'b11, a frame is accepted when R3 would accept it. A group address is identified by a 1 in the first received address bit. A group frame that is not broadcast is accepted exactly when `hash_table[hash_idx]` is 1. `hash_idx` is sampled in the cycle that carries the 48th address bit.
- R5: The k-th received address bit (k = 0..47) is compared with bit k of `sta_wdata` as written. Bit 47 is the most significant bit of the last station byte, and it is compared with the last bit received.
- R6: A frame is evaluated as follows:
  - `frame_start` begins an evaluation. `busy` goes to 1 and `verdict_valid` goes to 0 in the next cycle.
  - Address bits are taken on cycles with `bit_valid` = 1. Idle cycles between bits are allowed.
  - `verdict_valid` rises in the cycle after the 48th bit is taken, and `busy` falls in that same cycle.
  - `verdict_valid` and `accept` then hold until the next `frame_start`.
- R7: A station write (`sta_wr` = 1) takes effect only when no frame is being evaluated and `frame_start` is low. A write in the `frame_start` cycle is ignored, and so is a write while `busy` is 1.
- R8: The match mode is sampled in the `frame_start` cycle. Changing `match_mode` later in the frame does not affect that frame's verdict.
- R9: Address bits offered while the filter is idle are ignored: `verdict_valid` and `accept` do not change. A `frame_start` during an evaluation restarts it, and the bits taken so far are dropped.
- R10: After reset, `busy`, `verdict_valid` and `accept` are 0, the station address is all zeros and the mode is receiver off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe that opens a frame evaluation |
| bit_valid | input | 1 | `rx_bit` carries an address bit this cycle |
| rx_bit | input | 1 | Destination address bit, in wire order |
| match_mode | input | 2 | 00 off, 01 all, 10 station/broadcast, 11 station/broadcast/hashed group |
| hash_table | input | 64 | Group acceptance table, one bit per hash value |
| hash_idx | input | 6 | CRC-derived hash index, valid with the 48th address bit |
| sta_wr | input | 1 | Station address write strobe |
| sta_wdata | input | 48 | Station address, bit k matched against the k-th received bit |
| busy | output | 1 | A frame evaluation is in progress |
| verdict_valid | output | 1 | `accept` holds this frame's verdict |
| accept | output | 1 | 1 = keep the frame, 0 = discard it |

## Verification
The bench uses the default parameters: a 48-bit address and a 6-bit hash index, so all 64 table entries are reachable. With the full address width, the bench can test the two special bit positions separately:
- Position 0, which marks a group address. Flipping it turns the station address into a group address.
- Position 47, the last bit received. Flipping it yields a near miss that differs only in the final compare.

The 6-bit index lets neighbouring hash values be driven against a table with a single set bit, so one index accepts and the adjacent one discards. Evaluations run with and without idle gaps between bits. Some are interrupted by a restart, and some see station writes or mode changes mid-frame.

// File: rtl/raf_pkg.sv
package raf_pkg;

    typedef enum logic [1:0] {
        MM_OFF    = 2'b00,
        MM_ALL    = 2'b01,
        MM_DIRECT = 2'b10,
        MM_GROUP  = 2'b11
    } match_mode_e;

    typedef struct packed {
        logic station;
        logic bcast;
        logic group;
    } dest_hits_t;

    function automatic logic decide(match_mode_e mode, dest_hits_t hits, logic hash_bit);
        logic keep;
        case (mode)
            MM_OFF:    keep = 1'b0;
            MM_ALL:    keep = 1'b1;
            MM_DIRECT: keep = hits.station | hits.bcast;
            default:   keep = hits.station | hits.bcast | (hits.group & hash_bit);
        endcase
        return keep;
    endfunction

endpackage

// File: rtl/raf_bit_seq.sv
module raf_bit_seq #(
    parameter int ADDR_W = 48,
    localparam int CNT_W = $clog2(ADDR_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             bit_valid,
    output logic             busy,
    output logic [CNT_W-1:0] bit_idx,
    output logic             take,
    output logic             first,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_W - 1);

    assign take  = busy & bit_valid & ~frame_start;
    assign first = take & (bit_idx == '0);
    assign last  = take & (bit_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (frame_start) begin
            busy    <= 1'b1;
            bit_idx <= '0;
        end else if (take) begin
            if (last) begin
                busy    <= 1'b0;
                bit_idx <= '0;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/raf_dest_cmp.sv
module raf_dest_cmp
    import raf_pkg::*;
#(
    parameter int ADDR_W = 48,
    localparam int CNT_W = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              take,
    input  logic              first,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic              rx_bit,
    input  logic [ADDR_W-1:0] station,
    output dest_hits_t        hits_now
);
    logic sta_ok_q;
    logic bc_ok_q;
    logic grp_q;
    logic bit_eq;

    assign bit_eq = (rx_bit == station[bit_idx]);

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            sta_ok_q <= 1'b1;
            bc_ok_q  <= 1'b1;
            grp_q    <= 1'b0;
        end else if (take) begin
            sta_ok_q <= sta_ok_q & bit_eq;
            bc_ok_q  <= bc_ok_q & rx_bit;
            if (first) grp_q <= rx_bit;
        end
    end

    always_comb begin
        hits_now.station = sta_ok_q & bit_eq;
        hits_now.bcast   = bc_ok_q & rx_bit;
        hits_now.group   = first ? rx_bit : grp_q;
    end
endmodule

// File: rtl/raf_hash_sel.sv
module raf_hash_sel #(
    parameter int HASH_W = 6,
    localparam int TBL_N = 1 << HASH_W
) (
    input  logic [TBL_N-1:0]  tbl,
    input  logic [HASH_W-1:0] idx,
    output logic              hit
);
    assign hit = tbl[idx];
endmodule

// File: rtl/raf_station_reg.sv
module raf_station_reg #(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import raf_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6,
    localparam int CNT_W = $clog2(ADDR_W),
    localparam int TBL_N = 1 << HASH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              bit_valid,
    input  logic              rx_bit,
    input  logic [1:0]        match_mode,
    input  logic [TBL_N-1:0]  hash_table,
    input  logic [HASH_W-1:0] hash_idx,
    input  logic              sta_wr,
    input  logic [ADDR_W-1:0] sta_wdata,
    output logic              busy,
    output logic              verdict_valid,
    output logic              accept
);
    logic [CNT_W-1:0]  bit_idx;
    logic              take;
    logic              first;
    logic              last;
    logic [ADDR_W-1:0] sta_q;
    logic              sta_we;
    dest_hits_t        hits_now;
    logic              hash_hit;
    match_mode_e       mode_q;

    raf_bit_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .frame_start(frame_start), .bit_valid(bit_valid),
        .busy(busy), .bit_idx(bit_idx), .take(take), .first(first), .last(last)
    );

    assign sta_we = sta_wr & ~busy & ~frame_start;

    raf_station_reg #(.ADDR_W(ADDR_W)) u_sta (
        .clk(clk), .rst(rst), .wr_en(sta_we), .wdata(sta_wdata), .q(sta_q)
    );

    raf_dest_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .clk(clk), .rst(rst), .frame_start(frame_start), .take(take),
        .first(first), .bit_idx(bit_idx), .rx_bit(rx_bit),
        .station(sta_q), .hits_now(hits_now)
    );

    raf_hash_sel #(.HASH_W(HASH_W)) u_hash (
        .tbl(hash_table), .idx(hash_idx), .hit(hash_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MM_OFF;
        end else if (frame_start) begin
            mode_q <= match_mode_e'(match_mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            verdict_valid <= 1'b0;
            accept        <= 1'b0;
        end else if (last) begin
            verdict_valid <= 1'b1;
            accept        <= decide(mode_q, hits_now, hash_hit);
        end
    end
endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              bit_valid,
    input logic [1:0]        match_mode,
    input logic              busy,
    input logic              verdict_valid,
    input logic              accept,
    input logic [ADDR_W-1:0] sta_q
);
    logic [1:0] cap_mode;

    always_ff @(posedge clk) begin
        if (rst)              cap_mode <= 2'b00;
        else if (frame_start) cap_mode <= match_mode;
    end

    // R1
    off_discards_chk: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && cap_mode == 2'b00 |-> !accept);

    // R2
    all_accepts_chk: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && cap_mode == 2'b01 |-> accept);

    // R6
    verdict_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(verdict_valid) |-> $past(busy) && $past(bit_valid) && !busy);

    // R6
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && !frame_start |=> verdict_valid && $stable(accept));

    // R6
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !verdict_valid && busy);

    // R7
    sta_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy || frame_start |=> $stable(sta_q));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && !frame_start && !verdict_valid |=> !verdict_valid);
endmodule

bind rx_addr_filter raf_checker #(.ADDR_W(ADDR_W)) u_raf_checker (
    .clk(clk), .rst(rst), .frame_start(frame_start), .bit_valid(bit_valid),
    .match_mode(match_mode), .busy(busy), .verdict_valid(verdict_valid),
    .accept(accept), .sta_q(sta_q)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start;
    logic        bit_valid;
    logic        rx_bit;
    logic [1:0]  match_mode;
    logic [63:0] hash_table;
    logic [5:0]  hash_idx;
    logic        sta_wr;
    logic [47:0] sta_wdata;
    logic        busy;
    logic        verdict_valid;
    logic        accept;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string cur_req = "R10";

    localparam logic [47:0] STA_A = 48'h1234_5678_9ABC;
    localparam logic [47:0] STA_B = 48'h0246_8ACE_1350;
    localparam logic [47:0] BCAST = {48{1'b1}};
    localparam logic [47:0] GRP_M = 48'hA000_0000_0103;

    always #5 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst(rst), .frame_start(frame_start), .bit_valid(bit_valid),
        .rx_bit(rx_bit), .match_mode(match_mode), .hash_table(hash_table),
        .hash_idx(hash_idx), .sta_wr(sta_wr), .sta_wdata(sta_wdata),
        .busy(busy), .verdict_valid(verdict_valid), .accept(accept)
    );

    // behavioural reference model
    bit          m_busy, m_vv, m_acc;
    bit   [47:0] m_sta;
    bit   [1:0]  m_mode;
    bit          m_bits[$];

    function automatic bit ref_decide(bit [47:0] da, bit [47:0] sta, bit [1:0] mode,
                                      bit [63:0] tbl, bit [5:0] idx);
        bit st = (da == sta);
        bit bc = (da == {48{1'b1}});
        bit gp = da[0];
        case (mode)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return st | bc;
            default: return st | bc | (gp & tbl[idx]);
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_vv = 0; m_acc = 0; m_sta = '0; m_mode = 2'b00;
            m_bits.delete();
        end else if (frame_start) begin
            m_busy = 1; m_vv = 0; m_acc = 0; m_mode = match_mode;
            m_bits.delete();
        end else begin
            if (sta_wr && !m_busy) m_sta = sta_wdata;
            if (m_busy && bit_valid) begin
                m_bits.push_back(rx_bit);
                if (m_bits.size() == 48) begin
                    bit [47:0] da;
                    for (int k = 0; k < 48; k++) da[k] = m_bits[k];
                    m_acc  = ref_decide(da, m_sta, m_mode, hash_table, hash_idx);
                    m_vv   = 1;
                    m_busy = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            compared += 3;
            if (busy !== m_busy) begin
                mismatched++;
                $display("FAIL %s busy actual=%b expected=%b t=%0t", "R6", busy, m_busy, $time);
            end
            if (verdict_valid !== m_vv) begin
                mismatched++;
                $display("FAIL %s verdict_valid actual=%b expected=%b t=%0t", "R6", verdict_valid, m_vv, $time);
            end
            if (accept !== m_acc) begin
                mismatched++;
                $display("FAIL %s accept actual=%b expected=%b t=%0t", cur_req, accept, m_acc, $time);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 50000) begin
            mismatched++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            finish_run();
        end
    end

    task automatic wr_station(input logic [47:0] d);
        @(negedge clk); sta_wr = 1'b1; sta_wdata = d;
        @(negedge clk); sta_wr = 1'b0;
    endtask

    // wr_at: -1 none, -2 on frame_start cycle, else bit index; mode_at: -1 none
    task automatic send_frame(input logic [47:0] da, input int gap, input int wr_at,
                              input logic [47:0] wdata, input int mode_at, input logic [1:0] mval);
        @(negedge clk);
        frame_start = 1'b1; bit_valid = 1'b0;
        if (wr_at == -2) begin sta_wr = 1'b1; sta_wdata = wdata; end
        for (int k = 0; k < 48; k++) begin
            if (gap > 0 && k % gap == 1) begin
                @(negedge clk); frame_start = 1'b0; bit_valid = 1'b0; sta_wr = 1'b0;
            end
            @(negedge clk);
            frame_start = 1'b0; sta_wr = 1'b0;
            bit_valid = 1'b1; rx_bit = da[k];
            if (k == wr_at) begin sta_wr = 1'b1; sta_wdata = wdata; end
            if (k == mode_at) match_mode = mval;
        end
        @(negedge clk);
        bit_valid = 1'b0; sta_wr = 1'b0;
    endtask

    task automatic sendf(input logic [47:0] da, input logic exp, input string req);
        send_frame(da, 0, -1, '0, -1, 2'b00);
        chk(req, verdict_valid, 1'b1, "verdict_valid after frame");
        chk(req, accept, exp, "accept");
    endtask

    task automatic send_partial(input logic [47:0] da, input int n);
        @(negedge clk); frame_start = 1'b1; bit_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); frame_start = 1'b0; bit_valid = 1'b1; rx_bit = da[k];
        end
    endtask

    initial begin
        rst = 1'b1; frame_start = 0; bit_valid = 0; rx_bit = 0; match_mode = 2'b00;
        hash_table = 64'h10; hash_idx = 6'd4; sta_wr = 0; sta_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", busy, 1'b0, "busy after reset");
        chk("R10", verdict_valid, 1'b0, "verdict_valid after reset");
        chk("R10", accept, 1'b0, "accept after reset");
        match_mode = 2'b10;
        sendf(48'h0, 1'b1, "R10");

        wr_station(STA_A);
        // R1
        cur_req = "R1"; match_mode = 2'b00;
        sendf(STA_A, 1'b0, "R1");
        sendf(BCAST, 1'b0, "R1");
        // R2
        cur_req = "R2"; match_mode = 2'b01;
        sendf(48'h5555_0F0F_1234, 1'b1, "R2");
        sendf(GRP_M, 1'b1, "R2");
        // R3
        cur_req = "R3"; match_mode = 2'b10;
        sendf(STA_A, 1'b1, "R3");
        sendf(BCAST, 1'b1, "R3");
        sendf(STA_A ^ 48'h2, 1'b0, "R3");
        sendf(GRP_M, 1'b0, "R3");
        // R5
        cur_req = "R5";
        sendf(STA_A ^ (48'h1 << 47), 1'b0, "R5");
        sendf(STA_A ^ 48'h1, 1'b0, "R5");
        wr_station(STA_A | (48'h1 << 47));
        sendf(STA_A | (48'h1 << 47), 1'b1, "R5");
        sendf(STA_A, 1'b0, "R5");
        wr_station(STA_A);
        // R4
        cur_req = "R4"; match_mode = 2'b11;
        hash_table = 64'h10; hash_idx = 6'd4;
        sendf(GRP_M, 1'b1, "R4");
        hash_idx = 6'd5;
        sendf(GRP_M, 1'b0, "R4");
        hash_idx = 6'd4;
        sendf(48'h0000_1111_2222, 1'b0, "R4");
        hash_table = 64'h0;
        sendf(BCAST, 1'b1, "R4");
        sendf(STA_A, 1'b1, "R4");
        hash_table = 64'h8000_0000_0000_0000; hash_idx = 6'd63;
        send_frame(GRP_M, 3, -1, '0, -1, 2'b00);
        chk("R4", accept, 1'b1, "accept hashed group with gaps, idx 63");
        // R6 hold and clear
        cur_req = "R6";
        repeat (5) @(negedge clk);
        chk("R6", verdict_valid, 1'b1, "verdict held");
        chk("R6", accept, 1'b1, "accept held");
        frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        chk("R6", verdict_valid, 1'b0, "verdict cleared by frame_start");
        chk("R6", busy, 1'b1, "busy after frame_start");
        // R7
        cur_req = "R7"; match_mode = 2'b10; hash_table = 64'h10; hash_idx = 6'd4;
        send_frame(STA_A, 0, 10, STA_B, -1, 2'b00);
        chk("R7", accept, 1'b1, "write during frame ignored");
        sendf(STA_B, 1'b0, "R7");
        send_frame(STA_A, 0, -2, STA_B, -1, 2'b00);
        chk("R7", accept, 1'b1, "write at frame_start ignored");
        sendf(STA_B, 1'b0, "R7");
        wr_station(STA_B);
        sendf(STA_B, 1'b1, "R7");
        wr_station(STA_A);
        // R8
        cur_req = "R8"; match_mode = 2'b01;
        send_frame(48'h0F0F_0F0F_0F0E, 0, -1, '0, 20, 2'b00);
        chk("R8", accept, 1'b1, "mode change mid-frame ignored (01->00)");
        match_mode = 2'b00;
        send_frame(STA_A, 0, -1, '0, 5, 2'b01);
        chk("R8", accept, 1'b0, "mode change mid-frame ignored (00->01)");
        // R9
        cur_req = "R9"; match_mode = 2'b10;
        sendf(STA_A, 1'b1, "R9");
        for (int k = 0; k < 48; k++) begin
            @(negedge clk); bit_valid = 1'b1; rx_bit = k[0];
        end
        @(negedge clk); bit_valid = 1'b0;
        chk("R9", verdict_valid, 1'b1, "idle bits leave verdict");
        chk("R9", accept, 1'b1, "idle bits leave accept");
        chk("R9", busy, 1'b0, "idle bits do not start evaluation");
        send_partial(48'hFFFF_0000_FFFF, 20);
        sendf(STA_A, 1'b1, "R9");
        send_partial(STA_A, 30);
        sendf(48'h0000_1111_2223, 1'b0, "R9");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule